// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block lands incoming Ethernet frames in a circular receive area of local packet memory. The area is divided into 256-byte pages and is bounded by a programmable first page and a limit page, where the limit is one past the last usable page. A frame arrives as a byte stream marked with start, valid and last. The block owns the current-page pointer: every accepted frame begins at that page, and once the frame is complete the pointer moves to the page that follows it.

Before a frame is admitted, the block works out the free space between the current page and the host's boundary page. A frame is taken only when a maximum-size frame plus its header would fit and the receiver is not halted. A refused frame is still consumed from the stream, but nothing is written to memory. Data bytes go to memory first, starting four bytes into the base page and wrapping from the limit page back to the first page. After the last data byte, a four-byte header goes into the head of the base page: status, link page, length low byte, length high byte. The block then advances the current page, raises a sticky receive-done flag and publishes the status byte.

Top module: `rxring_writer`

## Requirements
- R1: After reset, mem_we, rx_irq and rx_status are 0 and cur_pg is 0x00.
- R2: A pulse on cur_ld loads cur_ld_val into cur_pg only when cur_ld_val is below MEM_END_PG (0xC0 by default). A larger value is ignored and cur_pg keeps its old value.
- R3: A frame is refused when stop_pg <= start_pg. It is also refused when the free space is below 1518 bytes (the maximum frame of 1514 plus 4). Free space in pages is bnd_pg - cur_pg when cur_pg < bnd_pg, and (stop_pg - start_pg) - (cur_pg - bnd_pg) otherwise, times 256. A refused frame is consumed up to its last byte with no memory write, no change to cur_pg and no rx_irq.
- R4: A frame whose start byte arrives while cmd_stop is 1 is refused in the same way as in R3.
- R5: After the last data byte, four header writes follow on consecutive cycles to byte offsets 0, 1, 2 and 3 of the base page. They carry, in that order: the status byte, the link page, total length bits 7:0, and total length bits 15:8. Total length is the frame byte count plus 4.
- R6: The link page is the base page plus ceil((total length + 4) / 256). If that reaches or passes stop_pg, (stop_pg - start_pg) is subtracted.
- R7: Data byte k of a frame is written one cycle after it is accepted. Byte 0 goes to base page * 256 + 4, and each later byte goes to the next address. An address equal to stop_pg * 256 is replaced by start_pg * 256.
- R8: The status byte is 0x01. Bit 5 (0x20) is also set when bit 0 of the frame's first byte is 1. rx_status takes this value when the frame completes.
- R9: On the clock edge of the last header write, cur_pg becomes the link page and rx_irq goes to 1. rx_irq stays at 1 until rx_irq_clr, and a completion in the same cycle wins over the clear.
- R10: When cur_pg is at or above MEM_END_PG, the base page of the next accepted frame is start_pg rather than cur_pg.
- R11: A frame of one byte, with start and last on the same beat, is stored as a frame of length 1 with total length 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stop | input | 1 | Receiver halted; frames starting now are refused |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | One past the last page of the ring |
| bnd_pg | input | 8 | Host boundary page (oldest unread page) |
| cur_ld | input | 1 | Load strobe for the current page |
| cur_ld_val | input | 8 | Value for the current-page load |
| in_valid | input | 1 | Frame byte valid |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_data | input | 8 | Frame byte |
| rx_irq_clr | input | 1 | Clears the receive-done flag |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_pg | output | 8 | Current page pointer |
| rx_irq | output | 1 | Sticky receive-done flag |
| rx_status | output | 8 | Status byte of the last stored frame |

## Verification
Every memory write appears one cycle after the beat that caused it. The four header writes follow the last data beat on the next four cycles, and cur_pg, rx_irq and rx_status change on the edge of the fourth header write. The bench computes the exact ordered list of addresses and bytes for each frame ahead of time and queues it. A monitor checks each write at the falling edge after it is issued, so no write can be early, late, missing or extra without a mismatch. Pointer, flag and status are checked only after a quiet gap of several cycles past the last header beat. Refused frames are checked by the lack of any write and by cur_pg and rx_irq holding their values.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_DATA = 2'd1,
      RS_DROP = 2'd2,
      RS_HDR  = 2'd3
   } rxr_state_e;

   localparam int          HDR_BYTES  = 4;
   localparam int          CRC_BYTES  = 4;
   localparam logic [7:0]  RXST_OK    = 8'h01;
   localparam logic [7:0]  RXST_GROUP = 8'h20;
endpackage

// File: rtl/rxr_space_chk.sv
module rxr_space_chk #(
   parameter int PAGE_W    = 8,
   parameter int OFF_W     = 8,
   parameter int MAX_FRAME = 1514
) (
   input  logic [PAGE_W-1:0] start_pg,
   input  logic [PAGE_W-1:0] stop_pg,
   input  logic [PAGE_W-1:0] cur_pg,
   input  logic [PAGE_W-1:0] bnd_pg,
   output logic              full
);
   import rxr_pkg::*;

   localparam int SW = PAGE_W + OFF_W + 2;

   logic signed [SW-1:0] sta_s, sto_s, cur_s, bnd_s;
   logic signed [SW-1:0] avail_pg, avail_b, need_b;

   always_comb begin
      sta_s = $signed(SW'(start_pg));
      sto_s = $signed(SW'(stop_pg));
      cur_s = $signed(SW'(cur_pg));
      bnd_s = $signed(SW'(bnd_pg));
      need_b = $signed(SW'(MAX_FRAME + HDR_BYTES));
      if (cur_s < bnd_s) begin
         avail_pg = bnd_s - cur_s;
      end else begin
         avail_pg = (sto_s - sta_s) - (cur_s - bnd_s);
      end
      avail_b = avail_pg <<< OFF_W;
      full    = (sto_s <= sta_s) || (avail_b < need_b);
   end
endmodule

// File: rtl/rxr_link_calc.sv
module rxr_link_calc #(
   parameter int PAGE_W = 8,
   parameter int OFF_W  = 8,
   parameter int CNT_W  = 16
) (
   input  logic [PAGE_W-1:0] base_pg,
   input  logic [PAGE_W-1:0] start_pg,
   input  logic [PAGE_W-1:0] stop_pg,
   input  logic [CNT_W-1:0]  frame_len,
   output logic [CNT_W-1:0]  total_len,
   output logic [PAGE_W-1:0] next_pg
);
   import rxr_pkg::*;

   localparam int LW         = CNT_W + 2;
   localparam int NW         = PAGE_W + LW + 1;
   localparam int PAGE_BYTES = 1 << OFF_W;

   logic [LW-1:0] span;
   logic [LW-1:0] pages;
   logic [NW-1:0] nxt;

   always_comb begin
      total_len = frame_len + CNT_W'(HDR_BYTES);
      span  = LW'(frame_len) + LW'(HDR_BYTES + CRC_BYTES) + LW'(PAGE_BYTES - 1);
      pages = span >> OFF_W;
      nxt   = NW'(base_pg) + NW'(pages);
      if (nxt >= NW'(stop_pg)) begin
         nxt = nxt - (NW'(stop_pg) - NW'(start_pg));
      end
      next_pg = nxt[PAGE_W-1:0];
   end
endmodule

// File: rtl/rxr_addr_step.sv
module rxr_addr_step #(
   parameter int PAGE_W = 8,
   parameter int OFF_W  = 8
) (
   input  logic [PAGE_W+OFF_W-1:0] addr,
   input  logic [PAGE_W-1:0]       start_pg,
   input  logic [PAGE_W-1:0]       stop_pg,
   output logic [PAGE_W+OFF_W-1:0] addr_next
);
   localparam int AW = PAGE_W + OFF_W;

   logic [AW-1:0] inc;

   always_comb begin
      inc = addr + AW'(1);
      if (inc == {stop_pg, {OFF_W{1'b0}}}) begin
         addr_next = {start_pg, {OFF_W{1'b0}}};
      end else begin
         addr_next = inc;
      end
   end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
   parameter int               PAGE_W     = 8,
   parameter int               OFF_W      = 8,
   parameter int               CNT_W      = 16,
   parameter int               MAX_FRAME  = 1514,
   parameter logic [PAGE_W-1:0] MEM_END_PG = 8'hC0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_stop,
   input  logic [PAGE_W-1:0]       start_pg,
   input  logic [PAGE_W-1:0]       stop_pg,
   input  logic [PAGE_W-1:0]       bnd_pg,
   input  logic                    cur_ld,
   input  logic [PAGE_W-1:0]       cur_ld_val,
   input  logic                    in_valid,
   input  logic                    in_sof,
   input  logic                    in_eof,
   input  logic [7:0]              in_data,
   input  logic                    rx_irq_clr,
   output logic                    mem_we,
   output logic [PAGE_W+OFF_W-1:0] mem_addr,
   output logic [7:0]              mem_wdata,
   output logic [PAGE_W-1:0]       cur_pg,
   output logic                    rx_irq,
   output logic [7:0]              rx_status
);
   import rxr_pkg::*;

   localparam int AW   = PAGE_W + OFF_W;
   localparam int HC_W = $clog2(HDR_BYTES);
   localparam logic [HC_W-1:0] HC_LAST = HC_W'(HDR_BYTES - 1);

   generate
      if (OFF_W < 3) begin : g_bad_off
         $error("OFF_W must allow a header inside one page");
      end
      if (CNT_W <= OFF_W) begin : g_bad_cnt
         $error("CNT_W must exceed OFF_W");
      end
      if (PAGE_W + OFF_W + 1 <= $clog2(MAX_FRAME + HDR_BYTES)) begin : g_bad_max
         $error("MAX_FRAME does not fit the space arithmetic");
      end
      if (HDR_BYTES != 4) begin : g_bad_hdr
         $error("header layout assumes four bytes");
      end
   endgenerate

   rxr_state_e        st_q;
   logic [PAGE_W-1:0] base_q;
   logic [AW-1:0]     waddr_q;
   logic [CNT_W-1:0]  len_q;
   logic [7:0]        stat_q;
   logic [HC_W-1:0]   hcnt_q;
   logic [PAGE_W-1:0] cur_q;
   logic              irq_q;
   logic [7:0]        rsr_q;
   logic              we_q;
   logic [AW-1:0]     addr_q;
   logic [7:0]        wdata_q;

   logic              full;
   logic              sof_beat;
   logic              accept;
   logic              hdr_done;
   logic [PAGE_W-1:0] base_now;
   logic [AW-1:0]     first_addr;
   logic [AW-1:0]     step_in;
   logic [AW-1:0]     step_out;
   logic [CNT_W-1:0]  total_len;
   logic [PAGE_W-1:0] link_pg;
   logic [7:0]        hdr_byte;

   rxr_space_chk #(
      .PAGE_W   (PAGE_W),
      .OFF_W    (OFF_W),
      .MAX_FRAME(MAX_FRAME)
   ) i_space (
      .start_pg(start_pg),
      .stop_pg (stop_pg),
      .cur_pg  (cur_q),
      .bnd_pg  (bnd_pg),
      .full    (full)
   );

   rxr_link_calc #(
      .PAGE_W(PAGE_W),
      .OFF_W (OFF_W),
      .CNT_W (CNT_W)
   ) i_link (
      .base_pg  (base_q),
      .start_pg (start_pg),
      .stop_pg  (stop_pg),
      .frame_len(len_q),
      .total_len(total_len),
      .next_pg  (link_pg)
   );

   rxr_addr_step #(
      .PAGE_W(PAGE_W),
      .OFF_W (OFF_W)
   ) i_step (
      .addr     (step_in),
      .start_pg (start_pg),
      .stop_pg  (stop_pg),
      .addr_next(step_out)
   );

   always_comb begin
      sof_beat   = in_valid && in_sof && (st_q == RS_IDLE);
      accept     = sof_beat && !cmd_stop && !full;
      hdr_done   = (st_q == RS_HDR) && (hcnt_q == HC_LAST);
      base_now   = (cur_q >= MEM_END_PG) ? start_pg : cur_q;
      first_addr = {base_now, OFF_W'(HDR_BYTES)};
      step_in    = (st_q == RS_IDLE) ? first_addr : waddr_q;
      case (hcnt_q)
         2'd0:    hdr_byte = stat_q;
         2'd1:    hdr_byte = 8'(link_pg);
         2'd2:    hdr_byte = total_len[7:0];
         default: hdr_byte = total_len[15:8];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RS_IDLE;
         base_q  <= '0;
         waddr_q <= '0;
         len_q   <= '0;
         stat_q  <= '0;
         hcnt_q  <= '0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         we_q <= 1'b0;
         case (st_q)
            RS_IDLE: begin
               if (accept) begin
                  base_q  <= base_now;
                  we_q    <= 1'b1;
                  addr_q  <= first_addr;
                  wdata_q <= in_data;
                  waddr_q <= step_out;
                  len_q   <= CNT_W'(1);
                  stat_q  <= RXST_OK | (in_data[0] ? RXST_GROUP : 8'h00);
                  hcnt_q  <= '0;
                  st_q    <= in_eof ? RS_HDR : RS_DATA;
               end else if (sof_beat) begin
                  st_q <= in_eof ? RS_IDLE : RS_DROP;
               end
            end
            RS_DATA: begin
               if (in_valid) begin
                  we_q    <= 1'b1;
                  addr_q  <= waddr_q;
                  wdata_q <= in_data;
                  waddr_q <= step_out;
                  len_q   <= len_q + CNT_W'(1);
                  if (in_eof) begin
                     st_q <= RS_HDR;
                  end
               end
            end
            RS_DROP: begin
               if (in_valid && in_eof) begin
                  st_q <= RS_IDLE;
               end
            end
            default: begin
               we_q    <= 1'b1;
               addr_q  <= {base_q, OFF_W'(hcnt_q)};
               wdata_q <= hdr_byte;
               hcnt_q  <= hcnt_q + HC_W'(1);
               if (hdr_done) begin
                  st_q <= RS_IDLE;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= '0;
         irq_q <= 1'b0;
         rsr_q <= '0;
      end else begin
         if (hdr_done) begin
            cur_q <= link_pg;
            rsr_q <= stat_q;
         end else if (cur_ld && (cur_ld_val < MEM_END_PG)) begin
            cur_q <= cur_ld_val;
         end
         if (hdr_done) begin
            irq_q <= 1'b1;
         end else if (rx_irq_clr) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign mem_we    = we_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign cur_pg    = cur_q;
   assign rx_irq    = irq_q;
   assign rx_status = rsr_q;

   // R5: the source leaves room for the header beats between frames
   hdr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RS_HDR) |-> !in_valid);

   // R3
   drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RS_DROP) |-> !mem_we);

   // R2
   load_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_ld && (cur_ld_val >= MEM_END_PG) && !hdr_done) |=> $stable(cur_pg));

   // R9
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> ($past(st_q) == RS_HDR));

   // R7
   data_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we) && (st_q == RS_DATA) && ($past(st_q) == RS_DATA))
      |-> ((mem_addr == $past(mem_addr) + AW'(1)) ||
           (mem_addr == {start_pg, {OFF_W{1'b0}}})));

   // R8
   status_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rx_status[0]);
endmodule

// File: tb/test_rxring_writer.sv
module test_rxring_writer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_stop = 1'b0;
   logic [7:0]  start_pg = '0, stop_pg = '0, bnd_pg = '0;
   logic        cur_ld = 1'b0;
   logic [7:0]  cur_ld_val = '0;
   logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
   logic [7:0]  in_data = '0;
   logic        rx_irq_clr = 1'b0;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  cur_pg;
   logic        rx_irq;
   logic [7:0]  rx_status;

   int errors = 0;
   int checks = 0;
   string tag = "R1";
   logic [23:0] exp_q[$];

   int m_cur = 0;
   int m_irq = 0;
   int m_stat = 0;

   always #5 clk = ~clk;

   rxring_writer i_rxring_writer (
      .clk(clk), .rst_n(rst_n), .cmd_stop(cmd_stop),
      .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
      .cur_ld(cur_ld), .cur_ld_val(cur_ld_val),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
      .rx_irq_clr(rx_irq_clr),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .cur_pg(cur_pg), .rx_irq(rx_irq), .rx_status(rx_status)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // monitor: every write must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: actual=write 0x%0h<=0x%0h expected=no write",
                     tag, mem_addr, mem_wdata);
         end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            if ({mem_addr, mem_wdata} != e) begin
               errors++;
               $display("FAIL %s: actual=0x%0h<=0x%0h expected=0x%0h<=0x%0h",
                        tag, mem_addr, mem_wdata, e[23:8], e[7:0]);
            end
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cfg(input int sta, input int sto, input int bnd, input int cur);
      @(posedge clk); #1;
      start_pg = 8'(sta); stop_pg = 8'(sto); bnd_pg = 8'(bnd);
      cur_ld = 1'b1; cur_ld_val = 8'(cur);
      @(posedge clk); #1;
      cur_ld = 1'b0;
      if (cur < 'hC0) m_cur = cur;
   endtask

   task automatic clear_irq();
      @(posedge clk); #1;
      rx_irq_clr = 1'b1;
      @(posedge clk); #1;
      rx_irq_clr = 1'b0;
      m_irq = 0;
   endtask

   // driver: model the expected writes, then feed the frame
   task automatic send_frame(input int n, input int b0, input string req);
      int sta, sto, avail, base, a, tot, nxt;
      bit acc;
      logic [7:0] b;
      tag = req;
      sta = start_pg; sto = stop_pg;
      if (m_cur < bnd_pg) avail = bnd_pg - m_cur;
      else avail = (sto - sta) - (m_cur - bnd_pg);
      acc = !cmd_stop && (sto > sta) && (avail * 256 >= 1518);
      if (acc) begin
         base = (m_cur >= 'hC0) ? sta : m_cur;
         a = base * 256 + 4;
         for (int i = 0; i < n; i++) begin
            b = (i == 0) ? 8'(b0) : 8'(i * 7 + 3);
            exp_q.push_back({16'(a), b});
            a++;
            if (a == sto * 256) a = sta * 256;
         end
         tot = n + 4;
         nxt = base + (tot + 4 + 255) / 256;
         if (nxt >= sto) nxt = nxt - (sto - sta);
         m_stat = ((b0 & 1) != 0) ? 'h21 : 'h01;
         exp_q.push_back({16'(base * 256 + 0), 8'(m_stat)});
         exp_q.push_back({16'(base * 256 + 1), 8'(nxt)});
         exp_q.push_back({16'(base * 256 + 2), 8'(tot)});
         exp_q.push_back({16'(base * 256 + 3), 8'(tot >> 8)});
         m_cur = nxt;
         m_irq = 1;
      end
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b1;
         in_sof = (i == 0);
         in_eof = (i == n - 1);
         in_data = (i == 0) ? 8'(b0) : 8'(i * 7 + 3);
      end
      @(posedge clk); #1;
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      cycles(8);
      check({req, " queue drained"}, exp_q.size(), 0);
      check({req, " cur_pg"}, cur_pg, m_cur);
      check({req, " rx_irq"}, rx_irq, m_irq);
      check({req, " rx_status"}, rx_status, m_stat);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cycles(3);
      // R1 reset state
      check("R1 mem_we", mem_we, 0);
      check("R1 rx_irq", rx_irq, 0);
      check("R1 rx_status", rx_status, 0);
      check("R1 cur_pg", cur_pg, 0);
      rst_n = 1'b1;
      cycles(2);

      cfg('h40, 'h60, 'h40, 'h40);
      send_frame(60, 'h00, "R5 R6 R7 R9 basic frame");
      send_frame(100, 'h01, "R8 group bit frame");
      clear_irq();
      cycles(1);
      check("R9 irq cleared", rx_irq, 0);
      send_frame(1, 'h02, "R11 single byte frame");
      clear_irq();

      cfg('h40, 'h60, 'h58, 'h5F);
      send_frame(300, 'h10, "R7 R6 wrap at stop");
      clear_irq();

      cfg('h40, 'h60, 'h52, 'h50);
      send_frame(60, 'h00, "R3 space short");
      cfg('h50, 'h50, 'h48, 'h40);
      send_frame(40, 'h00, "R3 stop not above start");
      cfg('h40, 'h60, 'h40, 'h40);
      cmd_stop = 1'b1;
      send_frame(40, 'h00, "R4 halted receiver");
      cmd_stop = 1'b0;
      send_frame(20, 'h04, "R4 resumes after halt");
      clear_irq();

      cfg('h40, 'h60, 'h40, 'hC0);
      check("R2 load above end ignored", cur_pg, m_cur);
      cfg('h40, 'h60, 'h40, 'hBF);
      check("R2 load below end taken", cur_pg, 'hBF);

      cfg('h80, 'hC4, 'h90, 'hBF);
      send_frame(300, 'h00, "R10 pointer lands past end");
      check("R10 cur past end", cur_pg, 'hC1);
      send_frame(60, 'h03, "R10 base falls back to start");

      cycles(4);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule